// File: doc/BRIEF.md
# Serial Slave Hold Gate

This block sits between the pins of a serial slave port and the protocol engine behind it. It watches chip select, the active-low hold input and the serial clock, all three sampled by a faster system clock through a synchronizer. When the host pulls hold low, the block suspends the transfer. The engine sees no clock edges while the transfer is suspended. Its bit counter and shift registers therefore keep their values, and the transfer carries on from the same bit once hold is released. No part of the sequence has to be sent again.

The serial clock level decides when the pause starts and when it ends. If hold drops while the serial clock is low, the pause starts at once. If hold drops while the serial clock is high, the pause starts at the next falling edge of the serial clock, and that edge is not passed to the engine. The pause ends only when hold is high and the serial clock is low at the same time. The serial output is forced to high impedance as soon as hold is seen low, even before the pause takes effect. It is also forced to high impedance while the slave is deselected.

If chip select rises during a pause, or while a pause is waiting to start, the pause is dropped and a one-cycle abort strobe tells the engine to discard the sequence. Command decoding is done by the engine, not by this block.

Top module: `spi_hold_gate`

## Requirements
- R1: When the synchronized pins show the slave selected, hold low and the serial clock low, `paused` is high one system clock later.
- R2: When hold goes low while the serial clock is high, `paused` stays low until the serial clock is seen low. The falling edge that starts the pause is not forwarded on `sck_fall_en`.
- R3: `paused` clears only when the synchronized pins show hold high and the serial clock low in the same sample, or when chip select goes high.
- R4: While `paused` is high, neither `sck_rise_en` nor `sck_fall_en` pulses, and `so_hiz` is high.
- R5: `so_hiz` is high whenever the synchronized hold level is low or the synchronized chip select is high, with no wait for the pause to begin.
- R6: If hold is released while the serial clock is high, the pause continues. It ends at the first sample that shows the serial clock low with hold still high. If hold falls again during this wait, the block returns to the plain paused condition.
- R7: If chip select is seen rising while a pause is active, pending or waiting to end, `paused` clears and `seq_abort` pulses high for exactly one system clock.
- R8: In normal running (selected, hold high, not paused), each serial clock rise produces one `sck_rise_en` pulse and each serial clock fall produces one `sck_fall_en` pulse. The pulse comes SYNC_STAGES+0 system clocks after the pin is sampled, counting from the edge that captures the pin.
- R9: After the synchronous reset, `paused` and `seq_abort` are low and `so_hiz` is high. The synchronizer holds the deselected idle levels: chip select high, hold high, serial clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| hold_n_pin | input | 1 | Hold pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| paused | output | 1 | Transfer is suspended; the engine freezes its state |
| so_hiz | output | 1 | Forces the serial output driver to high impedance |
| sck_rise_en | output | 1 | Qualified serial clock rising edge strobe for the engine |
| sck_fall_en | output | 1 | Qualified serial clock falling edge strobe for the engine |
| seq_abort | output | 1 | One-cycle strobe: the sequence was dropped during a pause |

## Verification
A wrong internal state shows up at the ports within SYNC_STAGES+1 system clocks of the pin change that exposes it. A stuck pending entry appears as `paused` staying low after the serial clock has fallen. A premature resume appears as edge strobes while hold is high but the serial clock is still high. A lost abort appears as `paused` staying high after chip select has risen. The bench compares every output against a behavioural reference on every clock, so any of these faults is seen on the first cycle it occurs, not at the end of a scenario.

// File: rtl/spi_hold_pkg.sv
`timescale 1ns/1ps
package spi_hold_pkg;

    localparam int PIN_W = 3;

    typedef struct packed {
        logic cs_n;
        logic hold_n;
        logic sck;
    } pin_t;

    localparam pin_t PIN_IDLE = '{cs_n: 1'b1, hold_n: 1'b1, sck: 1'b0};

    typedef enum logic [1:0] {
        HS_RUN    = 2'd0,
        HS_ARMED  = 2'd1,
        HS_PAUSED = 2'd2,
        HS_RESUME = 2'd3
    } hold_state_e;

    function automatic hold_state_e hold_next(input hold_state_e cur, input pin_t lvl);
        hold_state_e nxt;
        nxt = cur;
        if (lvl.cs_n) begin
            nxt = HS_RUN;
        end else begin
            case (cur)
                HS_RUN:    if (!lvl.hold_n) nxt = lvl.sck ? HS_ARMED : HS_PAUSED;
                HS_ARMED:  if (lvl.hold_n) nxt = HS_RUN;
                           else if (!lvl.sck) nxt = HS_PAUSED;
                HS_PAUSED: if (lvl.hold_n) nxt = lvl.sck ? HS_RESUME : HS_RUN;
                HS_RESUME: if (!lvl.hold_n) nxt = HS_PAUSED;
                           else if (!lvl.sck) nxt = HS_RUN;
                default:   nxt = HS_RUN;
            endcase
        end
        return nxt;
    endfunction

    function automatic logic is_frozen(input hold_state_e s);
        return (s == HS_PAUSED) || (s == HS_RESUME);
    endfunction

endpackage

// File: rtl/hold_pin_sync.sv
`timescale 1ns/1ps
module hold_pin_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hold_edge_detect.sv
`timescale 1ns/1ps
module hold_edge_detect
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pin_t cur,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    pin_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= PIN_IDLE;
        else     prev <= cur;
    end

    assign sck_rise = cur.sck & ~prev.sck;
    assign sck_fall = ~cur.sck & prev.sck;
    assign cs_rise  = cur.cs_n & ~prev.cs_n;
endmodule

// File: rtl/hold_fsm.sv
`timescale 1ns/1ps
module hold_fsm
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_t        lvl,
    input  logic        cs_rise,
    output hold_state_e state,
    output logic        abort_q
);
    hold_state_e nxt;

    always_comb nxt = hold_next(state, lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= HS_RUN;
            abort_q <= 1'b0;
        end else begin
            state   <= nxt;
            abort_q <= cs_rise && (state != HS_RUN);
        end
    end
endmodule

// File: rtl/spi_hold_gate.sv
`timescale 1ns/1ps
module spi_hold_gate
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_pin,
    input  logic hold_n_pin,
    input  logic sck_pin,
    output logic paused,
    output logic so_hiz,
    output logic sck_rise_en,
    output logic sck_fall_en,
    output logic seq_abort
);
    pin_t        raw;
    pin_t        lvl;
    logic [PIN_W-1:0] lvl_bits;
    logic        sck_rise, sck_fall, cs_rise;
    hold_state_e state;
    logic        run_ok;
    logic        lvl_cs, lvl_hold, lvl_sck;

    assign raw = '{cs_n: cs_n_pin, hold_n: hold_n_pin, sck: sck_pin};

    hold_pin_sync #(
        .STAGES (SYNC_STAGES),
        .W      (PIN_W),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (lvl_bits)
    );

    assign lvl = pin_t'(lvl_bits);

    hold_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .cur     (lvl),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .cs_rise (cs_rise)
    );

    hold_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .lvl    (lvl),
        .cs_rise(cs_rise),
        .state  (state),
        .abort_q(seq_abort)
    );

    assign lvl_cs   = lvl.cs_n;
    assign lvl_hold = lvl.hold_n;
    assign lvl_sck  = lvl.sck;

    assign run_ok      = ~lvl.cs_n & lvl.hold_n & (state == HS_RUN);
    assign paused      = is_frozen(state);
    assign so_hiz      = lvl.cs_n | ~lvl.hold_n | paused;
    assign sck_rise_en = sck_rise & run_ok;
    assign sck_fall_en = sck_fall & run_ok;
endmodule

// File: rtl/spi_hold_gate_chk.sv
`timescale 1ns/1ps
module spi_hold_gate_chk (
    input logic clk,
    input logic rst,
    input logic cs_s,
    input logic hold_s,
    input logic sck_s,
    input logic paused,
    input logic so_hiz,
    input logic rise_en,
    input logic fall_en,
    input logic abort
);
    // R1
    a_r1_enter_now: assert property (@(posedge clk) disable iff (rst)
        $past(!cs_s && !hold_s && !sck_s) |-> paused);

    // R2
    a_r2_entry_needs_sck_low: assert property (@(posedge clk) disable iff (rst)
        $rose(paused) |-> $past(!sck_s && !hold_s && !cs_s));

    // R3
    a_r3_exit_rule: assert property (@(posedge clk) disable iff (rst)
        ($fell(paused) && !$past(cs_s)) |-> $past(hold_s && !sck_s));

    // R4
    a_r4_no_edges: assert property (@(posedge clk) disable iff (rst)
        paused |-> (!rise_en && !fall_en && so_hiz));

    // R7
    a_r7_abort_clears: assert property (@(posedge clk) disable iff (rst)
        abort |-> (!paused && $past(cs_s)));

    // R7
    a_r7_abort_single: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort);
endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_s   (lvl_cs),
    .hold_s (lvl_hold),
    .sck_s  (lvl_sck),
    .paused (paused),
    .so_hiz (so_hiz),
    .rise_en(sck_rise_en),
    .fall_en(sck_fall_en),
    .abort  (seq_abort)
);

// File: tb/tb_spi_hold_gate.sv
`timescale 1ns/1ps
module tb_spi_hold_gate;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, hold_n = 1'b1, sck = 1'b0;
    logic paused, so_hiz, rise_en, fall_en, seq_abort;

    int checks = 0, failures = 0;
    int n_rise = 0, n_fall = 0, n_abort = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_hold_gate #(.SYNC_STAGES(N)) dut (
        .clk(clk), .rst(rst), .cs_n_pin(cs_n), .hold_n_pin(hold_n), .sck_pin(sck),
        .paused(paused), .so_hiz(so_hiz), .sck_rise_en(rise_en),
        .sck_fall_en(fall_en), .seq_abort(seq_abort)
    );

    // behavioural reference: delay line of pin samples plus a mode integer
    // mode: 0 running, 1 waiting for sck fall, 2 paused, 3 waiting for sck low
    logic [2:0] q [N];
    logic [2:0] old;
    int  mode = 0;
    logic e_paused, e_hiz, e_rise, e_fall, e_abort = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic s_cs, s_hold, s_sck;
        if (rst) begin
            for (int i = 0; i < N; i++) q[i] = 3'b110;
            old = 3'b110; mode = 0; e_abort = 0;
        end else begin
            s_cs = q[N-1][2]; s_hold = q[N-1][1]; s_sck = q[N-1][0];
            e_abort = s_cs && !old[2] && (mode != 0);
            if (s_cs) mode = 0;
            else if (mode == 0 && !s_hold) mode = s_sck ? 1 : 2;
            else if (mode == 1 && s_hold) mode = 0;
            else if (mode == 1 && !s_sck) mode = 2;
            else if (mode == 2 && s_hold) mode = s_sck ? 3 : 0;
            else if (mode == 3 && !s_hold) mode = 2;
            else if (mode == 3 && !s_sck) mode = 0;
            old = q[N-1];
            for (int i = N-1; i > 0; i--) q[i] = q[i-1];
            q[0] = {cs_n, hold_n, sck};
        end
        e_paused = (mode >= 2);
        e_hiz    = q[N-1][2] || !q[N-1][1] || e_paused;
        e_rise   = q[N-1][0] && !old[0] && !q[N-1][2] && q[N-1][1] && mode == 0;
        e_fall   = !q[N-1][0] && old[0] && !q[N-1][2] && q[N-1][1] && mode == 0;
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 paused", paused, e_paused);
            chk("R5 so_hiz", so_hiz, e_hiz);
            chk("R8 rise_en", rise_en, e_rise);
            chk("R4 fall_en", fall_en, e_fall);
            chk("R7 seq_abort", seq_abort, e_abort);
            if (rise_en) n_rise++;
            if (fall_en) n_fall++;
            if (seq_abort) n_abort++;
        end
    end

    task automatic pins(input logic c, input logic h, input logic s);
        @(posedge clk); #1;
        cs_n = c; hold_n = h; sck = s;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        n_rise = 0; n_fall = 0; n_abort = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R9 reset paused", paused, 1'b0);
        chk("R9 reset so_hiz", so_hiz, 1'b1);
        chk("R9 reset abort", seq_abort, 1'b0);

        // select and run four serial clock periods
        pins(0, 1, 0); settle(4); clr();
        for (int i = 0; i < 4; i++) begin
            pins(0, 1, 1); settle(2);
            pins(0, 1, 0); settle(2);
        end
        settle(3);
        chk_int("R8 rise count", n_rise, 4);
        chk_int("R8 fall count", n_fall, 4);
        chk("R8 so driven", so_hiz, 1'b0);

        // R1: hold low with sck low
        pins(0, 0, 0); settle(N + 1);
        chk("R1 paused now", paused, 1'b1);
        clr();
        for (int i = 0; i < 2; i++) begin
            pins(0, 0, 1); settle(2);
            pins(0, 0, 0); settle(2);
        end
        settle(3);
        chk_int("R4 rise while paused", n_rise, 0);
        chk_int("R4 fall while paused", n_fall, 0);
        pins(0, 1, 0); settle(N + 2);
        chk("R3 resume sck low", paused, 1'b0);

        // R2 and R5: hold low while sck high
        pins(0, 1, 1); settle(N + 2); clr();
        pins(0, 0, 1); settle(N + 3);
        chk("R2 deferred", paused, 1'b0);
        chk("R5 early hiz", so_hiz, 1'b1);
        pins(0, 0, 0); settle(N + 2);
        chk("R2 entered on fall", paused, 1'b1);
        chk_int("R2 fall suppressed", n_fall, 0);

        // R6: release while sck high
        pins(0, 0, 1); settle(N + 2);
        pins(0, 1, 1); settle(N + 3);
        chk("R6 wait sck low", paused, 1'b1);
        pins(0, 0, 1); settle(N + 2);
        chk("R6 hold low again", paused, 1'b1);
        pins(0, 1, 1); settle(N + 2); clr();
        pins(0, 1, 0); settle(N + 2);
        chk("R6 resumed", paused, 1'b0);
        chk_int("R6 no stray fall", n_fall, 0);

        // R7: chip select rise during pause
        pins(0, 0, 0); settle(N + 2);
        chk("R7 paused before", paused, 1'b1);
        clr();
        pins(1, 0, 0); settle(N + 3);
        chk_int("R7 abort pulses", n_abort, 1);
        chk("R7 paused cleared", paused, 1'b0);
        chk("R5 deselected hiz", so_hiz, 1'b1);

        // deselect with no pause: no abort
        pins(0, 1, 0); settle(N + 2); clr();
        pins(1, 1, 0); settle(N + 3);
        chk_int("R7 no abort when running", n_abort, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule